// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one data byte into an asynchronous serial frame on a single output line. An 8-bit line-control word sets the frame format. It chooses 5 to 8 data bits, whether a parity bit is sent, and how that parity bit is formed: odd, even, or held at a fixed level. It also sets the length of the stop interval, which is one bit time, two bit times, or one and a half bit times for 5-bit words. One bit of the same word is a break control that pulls the line low.

Time is measured in pulses of a baud tick input that runs at sixteen times the bit rate. A byte is offered with a valid/ready handshake. The block takes a snapshot of the format at the moment it accepts the byte, so format changes made during a frame apply only from the next frame. The top control bit is not used for framing. It is passed straight through to an output for the surrounding logic.

Top module: `uart_frame_tx`

## Requirements
- R1: Control bits [1:0] set the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits are sent least significant bit first.
- R2: The stop interval is high. It lasts 16 ticks when control bit 2 is 0. When bit 2 is 1 it lasts 24 ticks for a 5-bit length and 32 ticks for any other length.
- R3: When control bit 3 is 1, one parity bit of 16 ticks follows the data bits. When bit 3 is 0, the stop interval follows the last data bit directly.
- R4: With bit 3 = 1 and bit 5 = 0, bit 4 = 0 makes the count of ones in the data bits plus the parity bit odd, and bit 4 = 1 makes it even.
- R5: With bit 3 = 1 and bit 5 = 1, the parity bit is constant: 1 when bit 4 is 0, and 0 when bit 4 is 1.
- R6: While control bit 6 is 1, the serial output is low. A frame in progress is dropped, busy goes low and ready is low.
- R7: After bit 6 returns to 0, the line is high and ready stays low until exactly 16 baud ticks have occurred.
- R8: The line idles high. A frame begins with a 16-tick low start bit. Each data bit and the parity bit last 16 ticks.
- R9: The format is sampled when the byte is accepted. A change to control bits [5:0] during a frame does not alter that frame.
- R10: Control bit 7 is copied to the output divLatchEn and has no effect on the frame.
- R11: After reset the line is high, busy is 0 and ready is 1. A byte is accepted on a clock edge where txValid and txReady are both 1. Busy is 1 from the next cycle until the edge of the last stop tick. Ready is 1 only when not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| lineCtrl | input | 8 | Line-control word (format, break, latch flag) |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | txData is offered |
| txReady | output | 1 | Block accepts a byte on this edge |
| serialOut | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |
| divLatchEn | output | 1 | Copy of control bit 7 |

## Verification
If the tick counter or the bit index holds a wrong value, the serial line is wrong on the first baud tick that falls in the affected bit. A wrong value shifts the following edges by whole ticks, or drops or repeats a data bit, and the bench compares the line on every tick. A wrong format snapshot shows as a wrong parity level or stop length within one frame. A wrong idle count after a break shows as txReady rising before or after the sixteenth tick.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP   = 3'd4
  } txPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;    // accept byte, snapshot format
    logic     shift;   // advance to next data bit
    txPhase_e phase;   // which bit the line carries
  } txStrobe_t;

  // format fields that the control needs for timing
  typedef struct packed {
    logic [1:0] lenSel;
    logic       stopLong;
    logic       parityOn;
  } txTiming_t;

  // full snapshot held by the datapath
  typedef struct packed {
    logic [1:0] lenSel;
    logic       stopLong;
    logic       parityOn;
    logic       evenSel;
    logic       stickOn;
  } txFormat_t;

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      txValid,
  input  logic      brk,
  input  txTiming_t timing,
  output txStrobe_t strb,
  output logic      txReady,
  output logic      busy
);

  localparam int CNT_W  = $clog2(2 * TICKS_PER_BIT) + 1;
  localparam int IDLE_W = $clog2(TICKS_PER_BIT + 1);
  localparam logic [CNT_W-1:0]  BIT_T     = CNT_W'(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0]  HALF_T    = CNT_W'(TICKS_PER_BIT / 2);
  localparam logic [IDLE_W-1:0] IDLE_FULL = IDLE_W'(TICKS_PER_BIT);

  txPhase_e          phase;
  logic [CNT_W-1:0]  tickCnt;
  logic [2:0]        bitIdx;
  logic [IDLE_W-1:0] idleCnt;

  logic [CNT_W-1:0]  stopLen;
  logic [CNT_W-1:0]  phaseLen;
  logic [2:0]        lastIdx;
  logic              phaseEnd;
  logic              accept;

  always_comb begin
    stopLen = BIT_T;
    if (timing.stopLong)
      stopLen = BIT_T + ((timing.lenSel == 2'b00) ? HALF_T : BIT_T);
    phaseLen = (phase == PH_STOP) ? stopLen : BIT_T;
    lastIdx  = 3'd4 + {1'b0, timing.lenSel};
  end

  assign phaseEnd = baudTick && (tickCnt == phaseLen - CNT_W'(1));
  assign txReady  = (phase == PH_IDLE) && (idleCnt == IDLE_FULL) && !brk;
  assign accept   = txValid && txReady;
  assign busy     = (phase != PH_IDLE);

  always_comb begin
    strb.load  = accept;
    strb.shift = (phase == PH_DATA) && phaseEnd;
    strb.phase = phase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      idleCnt <= IDLE_FULL;
    end else if (brk) begin
      phase   <= PH_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      idleCnt <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (baudTick && idleCnt != IDLE_FULL) idleCnt <= idleCnt + IDLE_W'(1);
          if (accept) begin
            phase   <= PH_START;
            tickCnt <= '0;
            bitIdx  <= '0;
          end
        end
        default: begin
          if (baudTick) tickCnt <= phaseEnd ? '0 : tickCnt + CNT_W'(1);
          if (phaseEnd) begin
            unique case (phase)
              PH_START: begin
                phase  <= PH_DATA;
                bitIdx <= '0;
              end
              PH_DATA: begin
                if (bitIdx == lastIdx)
                  phase <= timing.parityOn ? PH_PARITY : PH_STOP;
                else
                  bitIdx <= bitIdx + 3'd1;
              end
              PH_PARITY: phase <= PH_STOP;
              PH_STOP: begin
                phase   <= PH_IDLE;
                idleCnt <= IDLE_FULL;
              end
              default: phase <= PH_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R6: a break drops any frame by the next cycle
  a_r6_break_drops: assert property (@(posedge clk) disable iff (!rstN)
    brk |=> (phase == PH_IDLE));

  // R11: ready never coexists with a frame in progress
  a_r11_ready_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> !busy);

  // R7: ready can only rise after a cycle with no break
  a_r7_ready_after_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReady) |-> $past(!brk));

  // R1: data index stays inside the selected length
  a_r1_index_bound: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |-> (bitIdx <= lastIdx));

  // R2: tick counter stays below the longest stop interval
  a_r2_tick_bound: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < CNT_W'(2 * TICKS_PER_BIT));

  // R3: the parity phase only occurs when parity is enabled
  a_r3_parity_gated: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PARITY) |-> timing.parityOn);

endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] lineCtrl,
  input  logic [7:0] txData,
  input  txStrobe_t  strb,
  output txTiming_t  timing,
  output logic       serialOut,
  output logic       divLatchEn
);

  txFormat_t fmtQ;
  logic [7:0] shiftReg;
  logic       parityQ;

  logic [7:0] lenMask;
  logic       onesOdd;
  logic       parityNext;
  logic       lineBit;

  always_comb begin
    lenMask = 8'hFF >> (2'd3 - lineCtrl[1:0]);
    onesOdd = ^(txData & lenMask);
    if (lineCtrl[5])      parityNext = ~lineCtrl[4];
    else if (lineCtrl[4]) parityNext = onesOdd;
    else                  parityNext = ~onesOdd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtQ     <= '0;
      shiftReg <= '0;
      parityQ  <= 1'b0;
    end else if (strb.load) begin
      fmtQ.lenSel   <= lineCtrl[1:0];
      fmtQ.stopLong <= lineCtrl[2];
      fmtQ.parityOn <= lineCtrl[3];
      fmtQ.evenSel  <= lineCtrl[4];
      fmtQ.stickOn  <= lineCtrl[5];
      shiftReg      <= txData;
      parityQ       <= parityNext;
    end else if (strb.shift) begin
      shiftReg <= {1'b0, shiftReg[7:1]};
    end
  end

  always_comb begin
    timing.lenSel   = fmtQ.lenSel;
    timing.stopLong = fmtQ.stopLong;
    timing.parityOn = fmtQ.parityOn;
  end

  always_comb begin
    unique case (strb.phase)
      PH_START:  lineBit = 1'b0;
      PH_DATA:   lineBit = shiftReg[0];
      PH_PARITY: lineBit = parityQ;
      default:   lineBit = 1'b1;
    endcase
  end

  assign serialOut  = lineBit && !lineCtrl[6];
  assign divLatchEn = lineCtrl[7];

  // R9: the snapshot holds for the whole frame
  a_r9_format_held: assert property (@(posedge clk) disable iff (!rstN)
    (strb.phase != PH_IDLE && !strb.load) |=> $stable(fmtQ));

  // R5: a stick parity snapshot carries the inverted level bit
  a_r5_stick_level: assert property (@(posedge clk) disable iff (!rstN)
    (strb.phase == PH_PARITY && fmtQ.stickOn) |-> (parityQ == !fmtQ.evenSel));

  // R8: the line is high during the stop interval unless in break
  a_r8_stop_high: assert property (@(posedge clk) disable iff (!rstN)
    (strb.phase == PH_STOP && !lineCtrl[6]) |-> serialOut);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic [7:0] lineCtrl,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  output logic       serialOut,
  output logic       busy,
  output logic       divLatchEn
);

  txStrobe_t strb;
  txTiming_t timing;

  uart_tx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .txValid  (txValid),
    .brk      (lineCtrl[6]),
    .timing   (timing),
    .strb     (strb),
    .txReady  (txReady),
    .busy     (busy)
  );

  uart_tx_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lineCtrl   (lineCtrl),
    .txData     (txData),
    .strb       (strb),
    .timing     (timing),
    .serialOut  (serialOut),
    .divLatchEn (divLatchEn)
  );

  // R11: an accepted byte starts a frame on the next cycle
  a_r11_accept_starts: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (busy || lineCtrl[6]));

  // R8: the line is low right after a byte is accepted
  a_r8_start_low: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !serialOut);

endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic [7:0] lineCtrl = 8'h03;
  logic [7:0] txData = 8'h00;
  logic       txValid = 1'b0;
  logic       txReady, serialOut, busy, divLatchEn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic samp [0:255];

  uart_frame_tx dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .lineCtrl(lineCtrl),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .serialOut(serialOut), .busy(busy), .divLatchEn(divLatchEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    baudTick <= ($urandom_range(0, 2) == 0);
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int frameTicks(input logic [7:0] c);
    int n = 5 + c[1:0];
    int st = 16;
    if (c[2]) st = (c[1:0] == 2'b00) ? 24 : 32;
    return 16 * (1 + n + (c[3] ? 1 : 0)) + st;
  endfunction

  function automatic logic expBit(input logic [7:0] d, input logic [7:0] c, input int i);
    int n = 5 + c[1:0];
    int pos = i / 16;
    logic ones = 1'b0;
    for (int k = 0; k < n; k++) ones ^= d[k];
    if (pos == 0) return 1'b0;
    if (pos <= n) return d[pos-1];
    if (c[3] && pos == n + 1) begin
      if (c[5]) return ~c[4];
      return c[4] ? ones : ~ones;
    end
    return 1'b1;
  endfunction

  // send one byte; optionally change lineCtrl to altCtrl after changeAt ticks
  task automatic sendFrame(input logic [7:0] d, input logic [7:0] c,
                           input int changeAt, input logic [7:0] altCtrl,
                           input string tag);
    int t = frameTicks(c);
    int n = 0;
    int bad = -1;
    @(negedge clk);
    lineCtrl = c;
    txData = d;
    txValid = 1'b1;
    while (!txReady) @(negedge clk);
    check(divLatchEn == c[7], "R10 latch flag copy", divLatchEn, c[7]);
    @(posedge clk);
    @(negedge clk);
    txValid = 1'b0;
    check(busy == 1'b1, "R11 busy after accept", busy, 1);
    while (n < t) begin
      if (baudTick) begin
        samp[n] = serialOut;
        n++;
        if (n == changeAt) lineCtrl = altCtrl;
      end
      if (n < t) @(negedge clk);
    end
    @(negedge clk);
    for (int i = 0; i < t; i++)
      if (bad < 0 && samp[i] !== expBit(d, c, i)) bad = i;
    check(bad < 0, {tag, " R1/R2/R3/R4/R5/R8 frame mismatch tick"}, bad, -1);
    check(busy == 1'b0 && serialOut == 1'b1, {tag, " R11/R2 idle after stop"},
          {busy, serialOut}, 1);
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(serialOut == 1'b1, "R8/R11 reset line high", serialOut, 1);
    check(busy == 1'b0, "R11 reset not busy", busy, 0);
    check(txReady == 1'b1, "R11 reset ready", txReady, 1);

    // directed: every length, stop and parity mode
    sendFrame(8'hA5, 8'h00, -1, 8'h00, "R1 5bit 1stop");
    sendFrame(8'hA5, 8'h04, -1, 8'h00, "R2 5bit 1.5stop");
    sendFrame(8'h3C, 8'h05, -1, 8'h00, "R2 6bit 2stop");
    sendFrame(8'h7E, 8'h0A, -1, 8'h00, "R4 7bit odd");
    sendFrame(8'h7E, 8'h1A, -1, 8'h00, "R4 7bit even");
    sendFrame(8'h81, 8'h2B, -1, 8'h00, "R5 stick one");
    sendFrame(8'h81, 8'h3B, -1, 8'h00, "R5 stick zero");
    sendFrame(8'hFF, 8'h87, -1, 8'h00, "R10 flag set 8bit");
    sendFrame(8'h00, 8'h08, -1, 8'h00, "R3 zero data odd");
    // R9: format change during frame is ignored
    sendFrame(8'h96, 8'h1F, 40, 8'h20, "R9 mid-frame change");
    sendFrame(8'h96, 8'h20, -1, 8'h00, "R9 next frame new format");

    // R6: break during a frame
    @(negedge clk);
    lineCtrl = 8'h03;
    txData = 8'h55;
    txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    txValid = 1'b0;
    repeat (100) @(negedge clk);
    lineCtrl = 8'h43;
    repeat (2) @(negedge clk);
    check(serialOut == 1'b0, "R6 break low", serialOut, 0);
    check(busy == 1'b0, "R6 frame dropped", busy, 0);
    check(txReady == 1'b0, "R6 not ready in break", txReady, 0);
    repeat (50) @(negedge clk);
    check(serialOut == 1'b0, "R6 break held", serialOut, 0);
    lineCtrl = 8'h03;
    cnt = 0;
    #1;
    check(serialOut == 1'b1, "R7 line high on release", serialOut, 1);
    while (!txReady) begin
      if (baudTick) cnt++;
      @(negedge clk);
    end
    check(cnt == 16, "R7 idle ticks before ready", cnt, 16);
    sendFrame(8'hC3, 8'h03, -1, 8'h00, "R7 frame after break");

    // R6/R7: break while idle
    @(negedge clk);
    lineCtrl = 8'h40;
    @(negedge clk);
    check(serialOut == 1'b0 && txReady == 1'b0, "R6 idle break", {serialOut, txReady}, 0);
    lineCtrl = 8'h00;
    cnt = 0;
    while (!txReady) begin
      if (baudTick) cnt++;
      @(negedge clk);
    end
    check(cnt == 16, "R7 idle break release ticks", cnt, 16);

    // random frames
    for (int i = 0; i < 40; i++) begin
      logic [7:0] c = 8'($urandom) & 8'hBF;
      sendFrame(8'($urandom), c, -1, 8'h00, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
  end

endmodule